// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the digital state of four digitally controlled potentiometers. Each potentiometer has an 8-bit wiper code that selects one of 256 taps, with code 0x00 at the low terminal and 0xFF at the high terminal. Each potentiometer also has four 8-bit preset registers. A preset can be copied into the wiper in one step, and the wiper can be saved back into any preset.

A serial front end decodes a command and presents it as a single-cycle strobe. The strobe carries a valid bit, an operation code, a potentiometer index, a preset index and a data byte. The command takes effect at the rising clock edge where `cmdValid` is high, and its result is visible on the outputs after that edge.

The four wiper codes leave the block as a packed vector. A one-hot tap vector per potentiometer models the tap switch array. A combinational read port returns either the wiper of a chosen potentiometer or one of its presets.

Top module: `quad_wiper_bank`

## Requirements
- R1: `wiperCodes[p*8 +: 8]` carries the wiper code of potentiometer p, for p = 0..3.
- R2: Operation 1 (write wiper) sets the wiper of pot `potSel` to `dataIn`, visible after the capturing edge.
- R3: Operation 2 writes `dataIn` into preset `regSel` of pot `potSel`. Operation 3 loads the wiper from preset `regSel`. Operation 4 stores the wiper into preset `regSel`. Each completes at the single capturing edge.
- R4: Operation 5 raises the selected wiper by one. Operation 6 lowers it by one.
- R5: Raising at 0xFF leaves 0xFF, and lowering at 0x00 leaves 0x00; codes never wrap.
- R6: A command changes only the selected pot's wiper, or only the selected preset of that pot. All other wipers and presets keep their values.
- R7: After the active-low asynchronous reset, every wiper and every preset reads 0x00.
- R8: `tapSel[p*256 +: 256]` has exactly one bit set, at the index equal to pot p's wiper code.
- R9: Operations 0 and 7, and any cycle with `cmdValid` low, change nothing.
- R10: With `rdWiper` = 1, `rdData` shows the wiper of `rdPot`. With `rdWiper` = 0, it shows preset `rdReg` of `rdPot`. The read path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Operation code |
| potSel | input | 2 | Target potentiometer |
| regSel | input | 2 | Target preset |
| dataIn | input | 8 | Data byte for writes |
| rdPot | input | 2 | Read port potentiometer |
| rdReg | input | 2 | Read port preset |
| rdWiper | input | 1 | Read port selects the wiper when 1 |
| rdData | output | 8 | Read data |
| wiperCodes | output | 32 | Four packed wiper codes |
| tapSel | output | 1024 | Four one-hot tap vectors |

## Verification
The bench drives stepping at both ends of the code range. A design that wraps would jump from 0xFF to 0x00 or from 0x00 to 0xFF. Loads and stores are sent to every preset index, so a wrong index decode would corrupt a neighbouring preset or load the wrong value. Commands to one pot are followed by reads of all the others; shared or mis-indexed enables would show up as changed neighbours. The unused operation code and strobes with the valid bit low are checked for leaving all state untouched. Random command streams are compared against a bench model of all twenty registers and of the tap vectors.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  localparam int CODE_W = 8;
  localparam int POT_W  = 2;
  localparam int REG_W  = 2;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_WR_WIPER  = 3'd1,
    OP_WR_PRESET = 3'd2,
    OP_LOAD      = 3'd3,
    OP_STORE     = 3'd4,
    OP_UP        = 3'd5,
    OP_DOWN      = 3'd6,
    OP_RSVD      = 3'd7
  } op_e;

  typedef struct packed {
    logic              wrWiper;
    logic              wrPreset;
    logic              loadWiper;
    logic              storePreset;
    logic              stepUp;
    logic              stepDown;
    logic [POT_W-1:0]  pot;
    logic [REG_W-1:0]  sel;
    logic [CODE_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/qwb_ctrl.sv
module qwb_ctrl
  import qwb_pkg::*;
(
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [POT_W-1:0]  potSel,
  input  logic [REG_W-1:0]  regSel,
  input  logic [CODE_W-1:0] dataIn,
  output strobe_t           strobe
);
  op_e opCode;
  assign opCode = op_e'(cmdOp);

  always_comb begin
    strobe             = '0;
    strobe.pot         = potSel;
    strobe.sel         = regSel;
    strobe.data        = dataIn;
    if (cmdValid) begin
      unique case (opCode)
        OP_WR_WIPER:  strobe.wrWiper     = 1'b1;
        OP_WR_PRESET: strobe.wrPreset    = 1'b1;
        OP_LOAD:      strobe.loadWiper   = 1'b1;
        OP_STORE:     strobe.storePreset = 1'b1;
        OP_UP:        strobe.stepUp      = 1'b1;
        OP_DOWN:      strobe.stepDown    = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/qwb_datapath.sv
module qwb_datapath
  import qwb_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      strobe,
  input  logic [POT_W-1:0]             rdPot,
  input  logic [REG_W-1:0]             rdReg,
  input  logic                         rdWiper,
  output logic [CODE_W-1:0]            rdData,
  output logic [NUM_POTS*CODE_W-1:0]   wiperCodes,
  output logic [NUM_POTS*(1<<CODE_W)-1:0] tapSel
);
  localparam int TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] wiperReg  [NUM_POTS];
  logic [CODE_W-1:0] presetReg [NUM_POTS][NUM_REGS];

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    logic hit;
    assign hit = (strobe.pot == POT_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiperReg[p] <= '0;
      end else if (hit) begin
        if (strobe.wrWiper)
          wiperReg[p] <= strobe.data;
        else if (strobe.loadWiper)
          wiperReg[p] <= presetReg[p][strobe.sel];
        else if (strobe.stepUp && wiperReg[p] != CODE_MAX)
          wiperReg[p] <= wiperReg[p] + 1'b1;
        else if (strobe.stepDown && wiperReg[p] != CODE_MIN)
          wiperReg[p] <= wiperReg[p] - 1'b1;
      end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic regHit;
      assign regHit = hit && (strobe.sel == REG_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          presetReg[p][r] <= '0;
        else if (regHit && strobe.wrPreset)
          presetReg[p][r] <= strobe.data;
        else if (regHit && strobe.storePreset)
          presetReg[p][r] <= wiperReg[p];
      end
    end

    assign wiperCodes[p*CODE_W +: CODE_W] = wiperReg[p];
    assign tapSel[p*TAPS +: TAPS] = {{(TAPS-1){1'b0}}, 1'b1} << wiperReg[p];
  end

  always_comb begin
    if (rdWiper) rdData = wiperReg[rdPot];
    else         rdData = presetReg[rdPot][rdReg];
  end
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
  import qwb_pkg::*;
#(
  parameter int NUM_POTS = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmdValid,
  input  logic [2:0]                       cmdOp,
  input  logic [POT_W-1:0]                 potSel,
  input  logic [REG_W-1:0]                 regSel,
  input  logic [CODE_W-1:0]                dataIn,
  input  logic [POT_W-1:0]                 rdPot,
  input  logic [REG_W-1:0]                 rdReg,
  input  logic                             rdWiper,
  output logic [CODE_W-1:0]                rdData,
  output logic [NUM_POTS*CODE_W-1:0]       wiperCodes,
  output logic [NUM_POTS*(1<<CODE_W)-1:0]  tapSel
);
  strobe_t strobe;

  qwb_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .potSel   (potSel),
    .regSel   (regSel),
    .dataIn   (dataIn),
    .strobe   (strobe)
  );

  qwb_datapath #(.NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rdPot      (rdPot),
    .rdReg      (rdReg),
    .rdWiper    (rdWiper),
    .rdData     (rdData),
    .wiperCodes (wiperCodes),
    .tapSel     (tapSel)
  );
endmodule

// File: rtl/qwb_checker.sv
module qwb_checker
  import qwb_pkg::*;
#(
  parameter int NUM_POTS = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cmdValid,
  input logic [2:0]                       cmdOp,
  input logic [POT_W-1:0]                 potSel,
  input logic [CODE_W-1:0]                dataIn,
  input logic [NUM_POTS*CODE_W-1:0]       wiperCodes,
  input logic [NUM_POTS*(1<<CODE_W)-1:0]  tapSel
);
  localparam int TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] selCode;
  assign selCode = wiperCodes[potSel*CODE_W +: CODE_W];

  AST_WRITE_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == OP_WR_WIPER) |=> wiperCodes[$past(potSel)*CODE_W +: CODE_W] == $past(dataIn)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == OP_UP && selCode != CODE_MAX)
      |=> wiperCodes[$past(potSel)*CODE_W +: CODE_W] == $past(selCode) + 1'b1); // R4

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == OP_UP && selCode == CODE_MAX)
      |=> wiperCodes[$past(potSel)*CODE_W +: CODE_W] == CODE_MAX); // R5

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == OP_DOWN && selCode == '0)
      |=> wiperCodes[$past(potSel)*CODE_W +: CODE_W] == '0); // R5

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_chk
    AST_OTHER_POT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmdValid && potSel == POT_W'(p)) |=> $stable(wiperCodes[p*CODE_W +: CODE_W])); // R6

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tapSel[p*TAPS +: TAPS]) == 1
        && tapSel[p*TAPS + int'(wiperCodes[p*CODE_W +: CODE_W])]); // R8
  end
endmodule

bind quad_wiper_bank qwb_checker #(.NUM_POTS(NUM_POTS)) u_qwb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .potSel     (potSel),
  .dataIn     (dataIn),
  .wiperCodes (wiperCodes),
  .tapSel     (tapSel)
);

// File: tb/quad_wiper_bank_bench.sv
module quad_wiper_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [1:0] potSel = '0, regSel = '0, rdPot = '0, rdReg = '0;
  logic [7:0] dataIn = '0;
  logic rdWiper = 1'b0;
  logic [7:0] rdData;
  logic [NP*8-1:0] wiperCodes;
  logic [NP*256-1:0] tapSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mWiper [NP];
  logic [7:0] mPreset [NP][NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_wiper_bank u_quad_wiper_bank (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .potSel(potSel), .regSel(regSel), .dataIn(dataIn),
    .rdPot(rdPot), .rdReg(rdReg), .rdWiper(rdWiper), .rdData(rdData),
    .wiperCodes(wiperCodes), .tapSel(tapSel)
  );

  function automatic logic [7:0] stepModel(logic [7:0] v, bit up);
    if (up) return (v == 8'hFF) ? v : v + 8'd1;
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyModel(logic [2:0] op, logic [1:0] p, logic [1:0] r, logic [7:0] d);
    case (op)
      3'd1: mWiper[p] = d;
      3'd2: mPreset[p][r] = d;
      3'd3: mWiper[p] = mPreset[p][r];
      3'd4: mPreset[p][r] = mWiper[p];
      3'd5: mWiper[p] = stepModel(mWiper[p], 1'b1);
      3'd6: mWiper[p] = stepModel(mWiper[p], 1'b0);
      default: ;
    endcase
  endtask

  task automatic doCmd(bit v, logic [2:0] op, logic [1:0] p, logic [1:0] r, logic [7:0] d);
    @(negedge clk);
    cmdValid = v; cmdOp = op; potSel = p; regSel = r; dataIn = d;
    @(posedge clk);
    if (v) applyModel(op, p, r, d);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkAll(string tag);
    for (int p = 0; p < NP; p++) begin
      check({tag, " R1 wiper"}, 32'(wiperCodes[p*8 +: 8]), 32'(mWiper[p]));
      check({tag, " R8 tap"}, 32'($countones(tapSel[p*256 +: 256])) << 1 | 32'(tapSel[p*256 + int'(mWiper[p])]), 32'd3);
      rdPot = 2'(p); rdWiper = 1'b1; #1;
      check({tag, " R10 rd wiper"}, 32'(rdData), 32'(mWiper[p]));
      for (int r = 0; r < NR; r++) begin
        rdReg = 2'(r); rdWiper = 1'b0; #1;
        check({tag, " R6 preset"}, 32'(rdData), 32'(mPreset[p][r]));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    for (int p = 0; p < NP; p++) begin
      mWiper[p] = '0;
      for (int r = 0; r < NR; r++) mPreset[p][r] = '0;
    end
    repeat (3) @(negedge clk);
    checkAll("R7 reset");
    rst_n = 1'b1;
    @(negedge clk);

    doCmd(1, 3'd1, 2'd2, 2'd0, 8'hA5);
    check("R2 write wiper", 32'(wiperCodes[23:16]), 32'hA5);
    checkAll("R6 after write");

    doCmd(1, 3'd1, 2'd1, 2'd0, 8'hFE);
    doCmd(1, 3'd5, 2'd1, 2'd0, 8'h00);
    check("R4 up", 32'(wiperCodes[15:8]), 32'hFF);
    doCmd(1, 3'd5, 2'd1, 2'd0, 8'h00);
    check("R5 top hold", 32'(wiperCodes[15:8]), 32'hFF);
    doCmd(1, 3'd1, 2'd3, 2'd0, 8'h01);
    doCmd(1, 3'd6, 2'd3, 2'd0, 8'h00);
    check("R4 down", 32'(wiperCodes[31:24]), 32'h00);
    doCmd(1, 3'd6, 2'd3, 2'd0, 8'h00);
    check("R5 bottom hold", 32'(wiperCodes[31:24]), 32'h00);

    for (int r = 0; r < NR; r++) doCmd(1, 3'd2, 2'd0, 2'(r), 8'(8'h10 + r));
    doCmd(1, 3'd3, 2'd0, 2'd2, 8'h00);
    check("R3 load", 32'(wiperCodes[7:0]), 32'h12);
    doCmd(1, 3'd4, 2'd2, 2'd3, 8'h00);
    rdPot = 2'd2; rdReg = 2'd3; rdWiper = 1'b0; #1;
    check("R3 store", 32'(rdData), 32'hA5);
    checkAll("R3 transfers");

    doCmd(1, 3'd7, 2'd2, 2'd1, 8'h33);
    doCmd(1, 3'd0, 2'd2, 2'd1, 8'h33);
    doCmd(0, 3'd1, 2'd2, 2'd1, 8'h33);
    doCmd(0, 3'd2, 2'd2, 2'd1, 8'h33);
    checkAll("R9 ignored");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) op = ($urandom_range(0, 1) != 0) ? 3'd5 : 3'd6;
      doCmd(($urandom_range(0, 9) != 0), op, 2'($urandom), 2'($urandom),
            ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
      if (i % 20 == 0) checkAll("R6 random");
    end
    checkAll("R10 final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule